// File: doc/BRIEF.md
# I2C Target with Configuration Register Bank

This block is a bus target that lets an I2C controller reach a small bank of 8-bit configuration registers. It runs on a fast system clock. It oversamples SCL and SDA through synchroniser chains and finds START, repeated START and STOP from the edges of those samples. A strap input chooses one of two device addresses, so two copies can share one bus. Every register drives a slice of a wide parallel output that the rest of the chip reads directly.

A write transaction sends the address byte, then a register pointer, then any number of data bytes. Each data byte goes into the pointed register, and the pointer then moves on by one. A read first sets the pointer with a short write, then uses a repeated START and the read form of the address byte. The target then shifts out registers MSB first, one per byte, for as long as the controller acknowledges each one. SDA is never driven high. The block only asserts a pull-down enable, and the pad ring turns it into an open-drain driver.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset every register reads 0x00 and the SDA pull-down enable is inactive.
- R2: With the select input low, the target answers address bytes 0xC0 (write) and 0xC1 (read). With it high, it answers 0xC2 and 0xC3. Byte bit 1 carries the select value and byte bit 0 is R/W. It acknowledges by pulling SDA low for the whole 9th SCL clock.
- R3: The target never acknowledges an address byte that does not match. It then keeps SDA released, and registers stay unchanged, until the next START.
- R4: In a write, the first byte after the address is the register pointer. Every following byte is stored in the pointed register. All of these bytes are acknowledged and taken MSB first.
- R5: The pointer advances by one after each stored or sent byte. It wraps from register 15 back to register 0.
- R6: After a pointer write, a repeated START and a matching read address, the target shifts out the pointed register MSB first, one bit per SCL clock. It then moves to the next register for each further byte.
- R7: During a read, a controller ACK (SDA low on the 9th clock) makes the target send the next register. A NACK makes it release SDA until the next START or STOP, so any further clocks read 0xFF.
- R8: A START or STOP in the middle of a byte abandons that byte: nothing is stored and SDA is released.
- R9: The target turns on its SDA pull-down only while SCL is low. It samples incoming bits on SCL rising edges.
- R10: Register i appears on bits [8i+7:8i] of the parallel output.
- R11: Only the low 4 bits of the pointer byte select a register. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| addr_sel_i | input | 1 | Selects the device address pair (0: 0xC0/0xC1, 1: 0xC2/0xC3) |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low; otherwise SDA is released |
| regs_o | output | 128 | All 16 registers side by side, register 0 in the low byte |

## Verification
Single-byte round trips run from a vector table that alternates the select input and uses pointer bytes with high bits set. These separate the two address pairs and show that only the low pointer bits pick a register. A three-byte burst followed by a three-byte read, and a second burst that starts at register 15, show ordering, auto-increment and wrap-around. Transactions addressed to the wrong pair, a NACK followed by extra clocks, and bytes cut short by a repeated START or a STOP show that nothing is stored and SDA stays released when it should.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

   // Protocol phase of the target
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,   // bus free, waiting for START
      PH_DEV   = 3'd1,   // receiving the address byte
      PH_PTR   = 3'd2,   // receiving the register pointer
      PH_WR    = 3'd3,   // receiving data bytes
      PH_RD    = 3'd4,   // sending data bytes
      PH_HOLD  = 3'd5    // not addressed or NACKed: wait for START/STOP
   } phase_e;

   localparam int unsigned BYTE_BITS = 8;

   // Seven-bit device address for a given select value
   function automatic logic [6:0] dev_address(input logic [6:0] base,
                                              input int unsigned sel_pos,
                                              input logic sel);
      logic [6:0] a;
      a = base;
      a[sel_pos] = sel;
      return a;
   endfunction

endpackage

// File: rtl/i2c_regbank_sync.sv
module i2c_regbank_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_regbank_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_d;
   logic              sda_d;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[0] <= 1'b1;
                  sda_ff[0] <= 1'b1;
               end else begin
                  scl_ff[0] <= scl_i;
                  sda_ff[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[g] <= 1'b1;
                  sda_ff[g] <= 1'b1;
               end else begin
                  scl_ff[g] <= scl_ff[g-1];
                  sda_ff[g] <= sda_ff[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_ff[STAGES-1];
         sda_d <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  =  scl_s & ~scl_d;
   assign scl_fall  = ~scl_s &  scl_d;
   assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
   assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/i2c_regbank_regs.sv
module i2c_regbank_regs #(
   parameter int unsigned NREG   = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned PTR_W = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [PTR_W-1:0]       wr_idx,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [PTR_W-1:0]       rd_idx,
   output logic [DATA_W-1:0]      rd_data,
   output logic [NREG*DATA_W-1:0] flat_o
);

   logic [DATA_W-1:0] bank [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) bank[i] <= '0;
      end else if (wr_en) begin
         bank[wr_idx] <= wr_data;
      end
   end

   assign rd_data = bank[rd_idx];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_flat
         assign flat_o[g*DATA_W +: DATA_W] = bank[g];
      end
   endgenerate

endmodule

// File: rtl/i2c_regbank_proto.sv
module i2c_regbank_proto
   import i2c_regbank_pkg::*;
#(
   parameter int unsigned NREG     = 16,
   parameter int unsigned DATA_W   = 8,
   parameter logic [6:0]  DEV_BASE = 7'h60,
   parameter int unsigned SEL_POS  = 0,
   localparam int unsigned PTR_W   = $clog2(NREG),
   localparam int unsigned CNT_W   = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic              addr_sel,
   input  logic [DATA_W-1:0] rd_data,
   output logic [PTR_W-1:0]  ptr_o,
   output logic              wr_en,
   output logic [PTR_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              sda_oe
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   phase_e            phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;
   logic [PTR_W-1:0]  ptr;
   logic              own_ack;
   logic [6:0]        my_addr;
   logic              dev_hit;

   assign my_addr = dev_address(DEV_BASE, SEL_POS, addr_sel);
   assign dev_hit = (rx_sh[DATA_W-1:1] == my_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         ptr     <= '0;
         own_ack <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            phase   <= PH_DEV;
            bit_cnt <= '0;
            own_ack <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            own_ack <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (phase == PH_IDLE || phase == PH_HOLD) begin
            sda_oe <= 1'b0;
         end else if (scl_rise) begin
            if (bit_cnt == LAST_BIT) begin
               // 9th clock: acknowledge slot
               bit_cnt <= '0;
               if (phase == PH_RD && !own_ack && sda_s) begin
                  phase <= PH_HOLD;
               end
            end else begin
               rx_sh   <= {rx_sh[DATA_W-2:0], sda_s};
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
               // a full byte has arrived or left: set up the ack slot
               unique case (phase)
                  PH_DEV: begin
                     if (dev_hit) begin
                        sda_oe  <= 1'b1;
                        own_ack <= 1'b1;
                        phase   <= rx_sh[0] ? PH_RD : PH_PTR;
                     end else begin
                        sda_oe  <= 1'b0;
                        phase   <= PH_HOLD;
                     end
                  end
                  PH_PTR: begin
                     ptr     <= rx_sh[PTR_W-1:0];
                     sda_oe  <= 1'b1;
                     own_ack <= 1'b1;
                     phase   <= PH_WR;
                  end
                  PH_WR: begin
                     wr_en   <= 1'b1;
                     wr_idx  <= ptr;
                     ptr     <= ptr + 1'b1;
                     sda_oe  <= 1'b1;
                     own_ack <= 1'b1;
                  end
                  PH_RD: begin
                     sda_oe  <= 1'b0;
                     own_ack <= 1'b0;
                  end
                  default: sda_oe <= 1'b0;
               endcase
            end else if (bit_cnt == '0) begin
               // after the ack slot: release, or load the next byte to send
               if (phase == PH_RD) begin
                  tx_sh   <= rd_data;
                  sda_oe  <= ~rd_data[DATA_W-1];
                  ptr     <= ptr + 1'b1;
                  own_ack <= 1'b0;
               end else begin
                  sda_oe  <= 1'b0;
               end
            end else if (phase == PH_RD) begin
               sda_oe <= ~tx_sh[DATA_W-1-int'(bit_cnt)];
            end
         end
      end
   end

   assign ptr_o   = ptr;
   assign wr_data = rx_sh;

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
   parameter int unsigned NREG        = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_BASE    = 7'h60,
   parameter int unsigned SEL_POS     = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   input  logic                   addr_sel_i,
   output logic                   sda_oe_o,
   output logic [NREG*DATA_W-1:0] regs_o
);

   localparam int unsigned PTR_W = $clog2(NREG);

   generate
      if (DATA_W != i2c_regbank_pkg::BYTE_BITS) begin : g_bad_width
         $error("i2c_regbank_target: DATA_W must equal the bus byte size");
      end
      if (NREG < 2 || (1 << PTR_W) != NREG) begin : g_bad_depth
         $error("i2c_regbank_target: NREG must be a power of two, at least 2");
      end
      if (NREG > 256) begin : g_bad_span
         $error("i2c_regbank_target: NREG must fit an 8-bit pointer");
      end
      if (SEL_POS > 6) begin : g_bad_sel
         $error("i2c_regbank_target: SEL_POS must lie within the 7-bit address");
      end
   endgenerate

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              wr_en;
   logic [PTR_W-1:0]  wr_idx;
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;

   i2c_regbank_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_regbank_proto #(
      .NREG     (NREG),
      .DATA_W   (DATA_W),
      .DEV_BASE (DEV_BASE),
      .SEL_POS  (SEL_POS)
   ) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .addr_sel  (addr_sel_i),
      .rd_data   (rd_data),
      .ptr_o     (ptr),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .sda_oe    (sda_oe_o)
   );

   i2c_regbank_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (ptr),
      .rd_data (rd_data),
      .flat_o  (regs_o)
   );

endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
   parameter int unsigned NREG   = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   scl_s,
   input logic                   start_det,
   input logic                   stop_det,
   input logic                   wr_en,
   input logic                   sda_oe_o,
   input logic [NREG*DATA_W-1:0] regs_o
);

   // R9: pull-down only switches on while SCL is low
   p_oe_on_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);

   // R8: START releases SDA
   p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_o);

   // R8: STOP releases SDA
   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   // R3: registers only change on a write strobe
   p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o));

   // R4: one store per received byte
   p_single_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R4: a store touches at most one register
   p_one_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ($countones(regs_o ^ $past(regs_o)) <= DATA_W));

endmodule

bind i2c_regbank_target i2c_regbank_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .wr_en     (wr_en),
   .sda_oe_o  (sda_oe_o),
   .regs_o    (regs_o)
);

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;

   localparam int NREG = 16;
   localparam int Q    = 8;    // system clocks per quarter SCL period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic addr_sel = 1'b0;
   logic sda_oe;
   logic [NREG*8-1:0] regs;
   logic sda_line;

   int tests = 0;
   int fails = 0;
   int oe_viol = 0;
   bit done = 1'b0;
   logic oe_prev = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   assign sda_line = sda_m & ~sda_oe;

   i2c_regbank_target u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .addr_sel_i (addr_sel),
      .sda_oe_o   (sda_oe),
      .regs_o     (regs)
   );

   // {select, pointer byte, data}
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 8'h00, 8'h5A},
      {1'b1, 8'h07, 8'hC3},
      {1'b0, 8'h0F, 8'h81},
      {1'b1, 8'h1B, 8'h3C},
      {1'b0, 8'hF4, 8'hFF},
      {1'b1, 8'h09, 8'h01}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qw();
      scl = 1'b1;   qw();
      sda_m = 1'b0; qw();
      scl = 1'b0;   qw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qw();
      scl = 1'b1;   qw();
      sda_m = 1'b1; qw();
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sda_m = v[i]; qw();
         scl = 1'b1;   qw(); qw();
         scl = 1'b0;   qw();
      end
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      send_bits(v, 8);
      sda_m = 1'b1; qw();
      scl = 1'b1;   qw();
      ack = ~sda_line;
      qw();
      scl = 1'b0;   qw();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; qw();
         scl = 1'b1;   qw();
         v[i] = sda_line;
         qw();
         scl = 1'b0;   qw();
      end
      sda_m = give_ack ? 1'b0 : 1'b1; qw();
      scl = 1'b1; qw(); qw();
      scl = 1'b0; qw();
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] reg_at(input int idx);
      return regs[idx*8 +: 8];
   endfunction

   // R9 monitor: a rising pull-down enable must never meet SCL high
   always @(negedge clk) begin
      if (rst_n && sda_oe && !oe_prev && scl) oe_viol++;
      oe_prev <= sda_oe;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] rb;
      logic [7:0] dev_w;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 regs after reset", 32'(regs == '0), 32'd1);
      chk("R1 sda released in reset", 32'(sda_oe), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 sda released after reset", 32'(sda_oe), 32'd0);

      // table: single-byte write then read back
      for (int k = 0; k < 6; k++) begin
         logic        sel;
         logic [7:0]  p;
         logic [7:0]  d;
         int          idx;
         {sel, p, d} = VEC[k];
         idx = int'(p[3:0]);
         addr_sel = sel;
         dev_w = sel ? 8'hC2 : 8'hC0;
         bus_start();
         send_byte(dev_w, ack);       chk($sformatf("R2 write addr ack row %0d", k), 32'(ack), 32'd1);
         send_byte(p, ack);           chk($sformatf("R4 pointer ack row %0d", k), 32'(ack), 32'd1);
         send_byte(d, ack);           chk($sformatf("R4 data ack row %0d", k), 32'(ack), 32'd1);
         bus_stop();
         qw();
         chk($sformatf("R10 R11 reg slice row %0d", k), 32'(reg_at(idx)), 32'(d));
         bus_start();
         send_byte(dev_w, ack);
         send_byte(p, ack);
         bus_start();
         send_byte(dev_w | 8'h01, ack); chk($sformatf("R2 read addr ack row %0d", k), 32'(ack), 32'd1);
         recv_byte(1'b0, rb);           chk($sformatf("R6 readback row %0d", k), 32'(rb), 32'(d));
         bus_stop();
         qw();
      end

      // burst write 0x0E,0x08,0xE1 from 0, burst read back (R5, R6, R7)
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'hC0, ack);
      send_byte(8'h00, ack);
      send_byte(8'h0E, ack); chk("R4 burst ack 0", 32'(ack), 32'd1);
      send_byte(8'h08, ack); chk("R4 burst ack 1", 32'(ack), 32'd1);
      send_byte(8'hE1, ack); chk("R4 burst ack 2", 32'(ack), 32'd1);
      bus_stop();
      qw();
      chk("R5 burst regs", {8'h00, reg_at(2), reg_at(1), reg_at(0)}, 32'h00E1080E);
      bus_start();
      send_byte(8'hC0, ack);
      send_byte(8'h00, ack);
      bus_start();
      send_byte(8'hC1, ack);
      recv_byte(1'b1, rb); chk("R6 burst read 0", 32'(rb), 32'h0E);
      recv_byte(1'b1, rb); chk("R7 ack continues 1", 32'(rb), 32'h08);
      recv_byte(1'b0, rb); chk("R7 ack continues 2", 32'(rb), 32'hE1);
      recv_byte(1'b0, rb); chk("R7 released after NACK", 32'(rb), 32'hFF);
      bus_stop();
      qw();

      // wrap from 15 to 0 (R5)
      bus_start();
      send_byte(8'hC0, ack);
      send_byte(8'h0F, ack);
      send_byte(8'hAA, ack);
      send_byte(8'h55, ack);
      bus_stop();
      qw();
      chk("R5 wrap reg15", 32'(reg_at(15)), 32'hAA);
      chk("R5 wrap reg0", 32'(reg_at(0)), 32'h55);

      // wrong address pair (R3)
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'hC2, ack); chk("R3 no ack wrong write addr", 32'(ack), 32'd0);
      send_byte(8'h03, ack); chk("R3 no ack after mismatch", 32'(ack), 32'd0);
      send_byte(8'h77, ack); chk("R3 no ack data after mismatch", 32'(ack), 32'd0);
      bus_stop();
      qw();
      chk("R3 reg3 unchanged", 32'(reg_at(3)), 32'h00);
      addr_sel = 1'b1;
      bus_start();
      send_byte(8'hC1, ack); chk("R3 no ack wrong read addr", 32'(ack), 32'd0);
      recv_byte(1'b1, rb);   chk("R3 line released", 32'(rb), 32'hFF);
      bus_stop();
      qw();

      // byte cut short by repeated START, then by STOP (R8)
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'hC0, ack);
      send_byte(8'h04, ack);
      send_bits(8'h05, 4);
      bus_start();
      bus_stop();
      qw();
      chk("R8 reg4 kept after START abort", 32'(reg_at(4)), 32'hFF);
      chk("R8 released after START abort", 32'(sda_oe), 32'd0);
      bus_start();
      send_byte(8'hC0, ack);
      send_byte(8'h06, ack);
      send_bits(8'h1B, 5);
      bus_stop();
      qw();
      chk("R8 reg6 kept after STOP abort", 32'(reg_at(6)), 32'h00);
      chk("R8 released after STOP abort", 32'(sda_oe), 32'd0);

      chk("R9 pull-down never rose with SCL high", 32'(oe_viol), 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule